// File: doc/BRIEF.md
# Power-Good and Fault Supervisor

This block is the digital supervisor beside a buck regulator. Comparators on the feedback node feed it three flags. The first is high while the feedback sits inside the regulation band, which is plus or minus 13 % around the 0.6 V target. The other two are high while the feedback is above or below the wider safe band, which is plus or minus 30 %. A fourth flag reports that soft-start has completed. The block time-filters every excursion and drives a power-good output. It also holds a latched fault that parks the power stage in a safe drive state, and it requests soft-shutdown discharge while power is not good.

The filter length is given in nanoseconds and turned into clock cycles from the clock period. The default is 7 µs. An excursion has to last for the whole filter length before it has any effect. A return to normal before then restarts the count from zero.

Power-good can only be withdrawn after it has been given at least once. Faults are armed only once regulation has been reached. A latched fault stays in place until reset or until the enable input is dropped.

Top module: `pg_fault_supervisor`

## Requirements
- R1: While reset is asserted and immediately after its release, every output is 0.
- R2: With `enable` high and no fault, power-good goes to 1 on the first clock edge at which `ss_done` and `fb_in_reg_win` are both sampled high. It stays 0 while `ss_done` is low.
- R3: Once power-good is high, `fb_in_reg_win` must be sampled low on FILT_CYC consecutive edges. Power-good then falls on the next edge. A shorter excursion has no effect, and any edge that samples it high restarts the count.
- R4: `discharge_req` is 1 exactly when power-good is 0 after it has been 1 at least once since enable. Before the first rise it stays 0.
- R5: Before power-good has first risen, over- or under-voltage flags of any length never set the fault.
- R6: Once armed, an over- or under-voltage flag sampled high on FILT_CYC consecutive edges sets `fault` on the next edge. Power-good drops to 0 on that same edge.
- R7: While `fault` is 1, `ls_force_on` and `hs_force_off` are both 1. All three stay 1 after the voltage flags clear, for as long as `enable` stays high.
- R8: When the fault is set, `ov_seen` records whether the over-voltage filter had expired and `uv_seen` records the under-voltage filter. Both hold for as long as the fault holds.
- R9: An edge that samples `enable` low clears the fault, both cause bits, power-good, arming and `discharge_req`.
- R10: FILT_CYC is FILT_NS divided by CLK_PERIOD_NS, rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock with a period of CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Supervisor enable; low clears all state |
| ss_done | input | 1 | Soft-start has completed |
| fb_in_reg_win | input | 1 | Feedback is inside the regulation band |
| fb_over_safe | input | 1 | Feedback is above the safe band |
| fb_under_safe | input | 1 | Feedback is below the safe band |
| pgood | output | 1 | Power-good indication |
| fault | output | 1 | Latched fault |
| ls_force_on | output | 1 | Command that holds the low-side switch on |
| hs_force_off | output | 1 | Command that holds the high-side switch off |
| discharge_req | output | 1 | Soft-shutdown discharge request |
| ov_seen | output | 1 | The fault was caused by over-voltage |
| uv_seen | output | 1 | The fault was caused by under-voltage |

## Verification
Wrong internal state in this block shows up at the ports as a timing error. A filter counter that restarts too late or too early moves the fall of power-good or the rise of the fault by at least one cycle, so the bench samples on both sides of the FILT_CYC boundary. A lost arming bit appears within FILT_CYC+1 cycles: either as a fault that follows an excursion during start-up, or as no fault at all after regulation has been reached. A fault latch that does not hold shows up the first cycle after the voltage flags clear.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    // Number of whole clock cycles that covers a window given in ns, minimum one
    function automatic int unsigned ns_to_cycles(input int unsigned win_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (win_ns + period_ns - 1) / period_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Indices of the filtered excursion channels
    localparam int unsigned CH_REG   = 0;
    localparam int unsigned CH_OVER  = 1;
    localparam int unsigned CH_UNDER = 2;
    localparam int unsigned N_CH     = 3;

    typedef struct packed {
        logic pgood;
        logic armed;
        logic fault;
        logic ov_cause;
        logic uv_cause;
    } sup_state_t;

endpackage

// File: rtl/pgs_excursion_filter.sv
module pgs_excursion_filter #(
    parameter int unsigned CYC = 700
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flag,
    output logic expired
);
    localparam int unsigned CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || !flag) begin
            cnt_d = '0;
        end else if (cnt_q == LIM) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);

    // R3: a sample of the normal level restarts the count
    a_r3_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag || clr) |=> (cnt_q == '0));

    // R3: the count never runs past its limit
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R3: expiry needs the flag to have been present on the previous edge
    a_r3_expiry_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(flag && !clr));

endmodule

// File: rtl/pgs_supervisor_core.sv
module pgs_supervisor_core
    import pgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ss_done,
    input  logic in_win,
    input  logic reg_exp,
    input  logic ov_exp,
    input  logic uv_exp,
    output logic pgood,
    output logic fault,
    output logic armed,
    output logic ov_cause,
    output logic uv_cause
);
    sup_state_t st_d, st_q;
    logic       fault_set;

    always_comb begin
        st_d      = st_q;
        fault_set = 1'b0;
        if (!enable) begin
            st_d = '0;
        end else begin
            fault_set  = (st_q.armed || st_q.pgood) && (ov_exp || uv_exp) && !st_q.fault;
            st_d.armed = st_q.armed || st_q.pgood;
            if (fault_set) begin
                st_d.fault    = 1'b1;
                st_d.ov_cause = ov_exp;
                st_d.uv_cause = uv_exp;
            end
            if (st_q.fault || fault_set) begin
                st_d.pgood = 1'b0;
            end else if (st_q.pgood) begin
                st_d.pgood = !reg_exp;
            end else begin
                st_d.pgood = ss_done && in_win;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pgood    = st_q.pgood;
    assign fault    = st_q.fault;
    assign armed    = st_q.armed;
    assign ov_cause = st_q.ov_cause;
    assign uv_cause = st_q.uv_cause;

    // R7: the fault holds while enabled
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && enable) |=> st_q.fault);

    // R5: a fault appears only after regulation was reached
    a_r5_fault_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> $past(st_q.armed || st_q.pgood));

    // R6: power-good and fault are never high together
    a_r6_no_pgood_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pgood && st_q.fault));

    // R2: power-good rises only after the start-up conditions were sampled
    a_r2_pgood_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pgood) |-> $past(enable && ss_done && in_win));

    // R9: dropping enable clears the latched state
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!st_q.fault && !st_q.pgood && !st_q.armed));

    // R8: a cause bit is only held together with a fault
    a_r8_cause_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov_cause || st_q.uv_cause) |-> st_q.fault);

endmodule

// File: rtl/pg_fault_supervisor.sv
module pg_fault_supervisor
    import pgs_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned FILT_NS       = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ss_done,
    input  logic fb_in_reg_win,
    input  logic fb_over_safe,
    input  logic fb_under_safe,
    output logic pgood,
    output logic fault,
    output logic ls_force_on,
    output logic hs_force_off,
    output logic discharge_req,
    output logic ov_seen,
    output logic uv_seen
);
    // R10: filter length in cycles, rounded up
    localparam int unsigned FILT_CYC = ns_to_cycles(FILT_NS, CLK_PERIOD_NS);

    logic [N_CH-1:0] exc_raw;
    logic [N_CH-1:0] exc_exp;
    logic            armed;

    assign exc_raw[CH_REG]   = !fb_in_reg_win;
    assign exc_raw[CH_OVER]  = fb_over_safe;
    assign exc_raw[CH_UNDER] = fb_under_safe;

    for (genvar g = 0; g < N_CH; g++) begin : g_filt
        pgs_excursion_filter #(.CYC(FILT_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!enable),
            .flag    (exc_raw[g]),
            .expired (exc_exp[g])
        );
    end

    pgs_supervisor_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .ss_done  (ss_done),
        .in_win   (fb_in_reg_win),
        .reg_exp  (exc_exp[CH_REG]),
        .ov_exp   (exc_exp[CH_OVER]),
        .uv_exp   (exc_exp[CH_UNDER]),
        .pgood    (pgood),
        .fault    (fault),
        .armed    (armed),
        .ov_cause (ov_seen),
        .uv_cause (uv_seen)
    );

    assign ls_force_on   = fault;
    assign hs_force_off  = fault;
    assign discharge_req = armed && !pgood;

    // R4: a discharge request never coexists with power-good
    a_r4_discharge_excludes_pgood: assert property (@(posedge clk) disable iff (!rst_n)
        !(discharge_req && pgood));

    // R3: power-good falls without a fault only after the band filter expired
    a_r3_fall_needs_filter: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pgood) && !fault) |-> $past(!enable || exc_exp[CH_REG]));

endmodule

// File: tb/pg_fault_supervisor_bench.sv
module pg_fault_supervisor_bench;
    localparam int unsigned CLK_NS  = 10;
    localparam int unsigned FILT_NS = 95;
    localparam int unsigned N       = 10;  // R10: ceil(95/10)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, ss_done = 1'b0, in_win = 1'b0, ov = 1'b0, uv = 1'b0;
    logic pgood, fault, ls_on, hs_off, dis, ov_s, uv_s;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    pg_fault_supervisor #(.CLK_PERIOD_NS(CLK_NS), .FILT_NS(FILT_NS)) u_pg_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
        .fb_in_reg_win(in_win), .fb_over_safe(ov), .fb_under_safe(uv),
        .pgood(pgood), .fault(fault), .ls_force_on(ls_on), .hs_force_off(hs_off),
        .discharge_req(dis), .ov_seen(ov_s), .uv_seen(uv_s)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1", "pgood in reset", pgood, 1'b0);
        chk("R1", "fault in reset", fault, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "discharge after reset", dis, 1'b0);
        chk("R1", "drive after reset", ls_on | hs_off | ov_s | uv_s, 1'b0);
    endtask

    task automatic t_startup();
        enable = 1'b1; in_win = 1'b1;
        step(3);
        chk("R2", "pgood without ss_done", pgood, 1'b0);
        chk("R4", "no discharge before first rise", dis, 1'b0);
        ov = 1'b1;
        step(2 * N);
        chk("R5", "no fault before arming", fault, 1'b0);
        ov = 1'b0;
        ss_done = 1'b1;
        step(1);
        chk("R2", "pgood after ss_done", pgood, 1'b1);
    endtask

    task automatic t_filter();
        in_win = 1'b0; step(N - 1); in_win = 1'b1; step(3);
        chk("R3", "short excursion ignored", pgood, 1'b1);
        in_win = 1'b0; step(N - 1); in_win = 1'b1; step(1);
        in_win = 1'b0; step(N - 1); in_win = 1'b1; step(1);
        chk("R3", "restart on return", pgood, 1'b1);
        in_win = 1'b0; step(N);
        chk("R3", "pgood at N samples", pgood, 1'b1);
        step(1);
        chk("R3", "pgood after N+1 edges", pgood, 1'b0);
        chk("R4", "discharge when not good", dis, 1'b1);
        in_win = 1'b1; step(1);
        chk("R2", "pgood recovers", pgood, 1'b1);
        chk("R4", "discharge cleared", dis, 1'b0);
    endtask

    task automatic t_ov_fault();
        ov = 1'b1; step(N);
        chk("R6", "no fault at N samples", fault, 1'b0);
        step(1);
        chk("R6", "fault after N+1 edges", fault, 1'b1);
        chk("R6", "pgood dropped by fault", pgood, 1'b0);
        chk("R7", "low side forced on", ls_on, 1'b1);
        chk("R7", "high side forced off", hs_off, 1'b1);
        chk("R8", "ov cause", ov_s, 1'b1);
        chk("R8", "uv cause clear", uv_s, 1'b0);
        chk("R4", "discharge in fault", dis, 1'b1);
        ov = 1'b0; step(5);
        chk("R7", "fault latched", fault, 1'b1);
        chk("R7", "drive latched", ls_on & hs_off, 1'b1);
        chk("R8", "ov cause held", ov_s, 1'b1);
        chk("R7", "pgood held low in fault", pgood, 1'b0);
    endtask

    task automatic t_clear_uv();
        enable = 1'b0; step(1);
        chk("R9", "fault cleared", fault, 1'b0);
        chk("R9", "cause cleared", ov_s | uv_s, 1'b0);
        chk("R9", "discharge cleared", dis, 1'b0);
        chk("R9", "pgood cleared", pgood, 1'b0);
        enable = 1'b1; step(1);
        chk("R2", "pgood after re-enable", pgood, 1'b1);
        uv = 1'b1; in_win = 1'b0; step(N + 1);
        chk("R6", "uv fault", fault, 1'b1);
        chk("R8", "uv cause", uv_s, 1'b1);
        chk("R8", "ov cause clear", ov_s, 1'b0);
        uv = 1'b0; in_win = 1'b1;
    endtask

    initial begin
        t_reset();
        t_startup();
        t_filter();
        t_ov_fault();
        t_clear_uv();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule